// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block watches for a stalled program. It counts ticks of a slow free-running clock and raises a reset request for the whole controller when the count overflows. To keep the request away, software must keep writing one fixed key byte (0x5A) into a write-only clear register, which the bus decodes with an address-match strobe. The clear starts in the bus clock domain. A toggle synchronizer carries it into the slow clock domain, so a clear is never lost, whatever the phase between the two clocks.

A static configuration input sets the operating mode, and it changes only while the block is held in reset. The watchdog can be disabled. It can be enabled only while the core runs, in which case it holds its count during the idle and power-down states. It can also be always on, in which case it keeps counting through every power state. The reset request is a pulse of a fixed number of slow-clock cycles. The count wraps to zero at overflow and keeps running.

Top module: `kwdt`

## Requirements
- R1: With counting enabled, the count advances by one on each slow-clock edge. The reset request rises on the edge that completes 2^CNT_W enabled ticks after the count was last cleared. With the default CNT_W=13, that is 8192 ticks.
- R2: On overflow the count wraps to zero and keeps counting. `wdt_rst_req` stays high for exactly RST_LEN slow-clock edges (default 2).
- R3: A write with `bus_sel`=1, `bus_we`=1 and `bus_wdata`=0x5A sets the count to zero. This happens on the third slow-clock edge after the write, provided the write ends at least one bus cycle before the first of those edges.
- R4: A write with any other data value has no effect on the count. So does a key-valued cycle without `bus_sel`, or with `bus_we` low.
- R5: With `cfg_mode`=2'b01 (run-only), the count advances only while `pwr_state`=2'b00 (run). In green (2'b01), power-down (2'b10) or the reserved code 2'b11, it holds its value, and it resumes on return to run.
- R6: With `cfg_mode`=2'b10 or 2'b11 (always on), the count advances in every `pwr_state`.
- R7: With `cfg_mode`=2'b00 (disabled), the count stays at zero and `wdt_rst_req` never rises.
- R8: While `rst_n` is low, `wdt_rst_req` is low, including when the reset arrives in the middle of a pulse. After reset the count starts again from zero.
- R9: A read cycle (`bus_sel`=1, `bus_re`=1) returns 0x00 on `bus_rdata` and has no effect on the count, even when `bus_wdata` holds 0x5A.
- R10: A key write is never dropped, whatever its phase to the slow clock. It clears the count on the third or fourth slow-clock edge after the write starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| sclk | input | 1 | Slow low-speed oscillator clock that drives the count |
| cfg_mode | input | 2 | Static mode: 00 disabled, 01 run-only, 10/11 always on |
| pwr_state | input | 2 | Power state: 00 run, 01 green, 10 power-down, 11 reserved (power-down) |
| bus_sel | input | 1 | Address matches the clear register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, always 0x00 for this register |
| wdt_rst_req | output | 1 | Reset request pulse to the reset controller |

## Verification
The assertions take two things for granted. First, `cfg_mode` changes only while reset is held. Second, `pwr_state` changes away from slow-clock rising edges, so the slow domain samples it without a synchronizer. The stimulus changes `pwr_state` only at slow falling edges and changes the mode only inside a reset sequence. The toggle-based clear transfer also assumes that two key writes are at least three slow cycles apart. The bench therefore leaves several slow edges between clears, and the only key writes placed near a slow edge are single, isolated writes.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RUNONLY = 2'b01,
    MODE_ALWAYS  = 2'b10,
    MODE_ALWAYS2 = 2'b11
  } wdt_mode_e;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_GREEN = 2'b01,
    PWR_DOWN  = 2'b10,
    PWR_RSVD  = 2'b11
  } pwr_state_e;

  // Counting is allowed in always-on modes, or in run-only mode while running.
  function automatic logic tick_allowed(input wdt_mode_e mode, input pwr_state_e pwr);
    logic ok;
    case (mode)
      MODE_OFF:     ok = 1'b0;
      MODE_RUNONLY: ok = (pwr == PWR_RUN);
      default:      ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/kwdt_rst_sync.sv
module kwdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_out = sh_q[STAGES-1];

endmodule

// File: rtl/kwdt_keydec.sv
module kwdt_keydec #(
  parameter int          DATA_W = 8,
  parameter logic [7:0]  KEY    = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clr_tog
);

  localparam logic [DATA_W-1:0] KEY_W   = DATA_W'(KEY);
  localparam logic [DATA_W-1:0] RD_ZERO = '0;

  logic key_hit;
  logic tog_q;
  logic tog_d;

  always_comb begin
    key_hit = bus_sel & bus_we & (bus_wdata == KEY_W);
    tog_d   = tog_q ^ key_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (key_hit) begin
      tog_q <= tog_d;
    end
  end

  // The clear register is write-only; a read returns zero and changes nothing.
  assign bus_rdata = (bus_sel & bus_re) ? RD_ZERO : '0;
  assign clr_tog   = tog_q;

endmodule

// File: rtl/kwdt_xfer.sv
module kwdt_xfer #(
  parameter int STAGES = 2
) (
  input  logic sclk,
  input  logic srst_n,
  input  logic tog_in,
  output logic clr_pulse
);

  logic [STAGES:0] sync_q;
  logic [STAGES:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-1:0], tog_in};
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  // Any change of the synchronized toggle is one clear request.
  assign clr_pulse = sync_q[STAGES] ^ sync_q[STAGES-1];

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int RST_LEN = 2
) (
  input  logic             sclk,
  input  logic             srst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       pwr_state,
  input  logic             clr_pulse,
  output logic [CNT_W-1:0] count,
  output logic             rst_req
);

  localparam int               RCNT_W  = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [RCNT_W-1:0] RLOAD  = RCNT_W'(RST_LEN);

  wdt_mode_e   mode;
  pwr_state_e  pwr;
  logic        tick_en;
  logic        wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [RCNT_W-1:0] rcnt_q;
  logic [RCNT_W-1:0] rcnt_d;
  logic        req_q;
  logic        req_d;

  always_comb begin
    mode    = wdt_mode_e'(cfg_mode);
    pwr     = pwr_state_e'(pwr_state);
    tick_en = tick_allowed(mode, pwr);
    wrap    = 1'b0;
    cnt_d   = cnt_q;
    if (mode == MODE_OFF) begin
      cnt_d = '0;
    end else if (clr_pulse) begin
      cnt_d = '0;
    end else if (tick_en) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = (cnt_q == CNT_TOP);
    end
  end

  always_comb begin
    if (wrap) begin
      rcnt_d = RLOAD;
    end else if (rcnt_q != '0) begin
      rcnt_d = rcnt_q - 1'b1;
    end else begin
      rcnt_d = rcnt_q;
    end
    req_d = (rcnt_d != '0);
  end

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= '0;
      rcnt_q <= '0;
      req_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rcnt_q <= rcnt_d;
      req_q  <= req_d;
    end
  end

  assign count   = cnt_q;
  assign rst_req = req_q;

endmodule

// File: rtl/kwdt.sv
module kwdt #(
  parameter int         CNT_W       = 13,
  parameter int         RST_LEN     = 2,
  parameter int         SYNC_STAGES = 2,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] KEY         = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        pwr_state,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_req
);

  logic             brst_n;
  logic             srst_n;
  logic             clr_tog;
  logic             clr_pulse;
  logic [CNT_W-1:0] count_q;

  kwdt_rst_sync #(.STAGES(2)) u_bus_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (brst_n)
  );

  kwdt_rst_sync #(.STAGES(2)) u_slow_rst (
    .clk       (sclk),
    .rst_n_in  (rst_n),
    .rst_n_out (srst_n)
  );

  kwdt_keydec #(.DATA_W(DATA_W), .KEY(KEY)) u_keydec (
    .clk       (clk),
    .rst_n     (brst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clr_tog   (clr_tog)
  );

  kwdt_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
    .sclk      (sclk),
    .srst_n    (srst_n),
    .tog_in    (clr_tog),
    .clr_pulse (clr_pulse)
  );

  kwdt_core #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_core (
    .sclk      (sclk),
    .srst_n    (srst_n),
    .cfg_mode  (cfg_mode),
    .pwr_state (pwr_state),
    .clr_pulse (clr_pulse),
    .count     (count_q),
    .rst_req   (wdt_rst_req)
  );

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
  parameter int         CNT_W   = 13,
  parameter int         RST_LEN = 2,
  parameter int         DATA_W  = 8,
  parameter logic [7:0] KEY     = 8'h5A
) (
  input logic              clk,
  input logic              sclk,
  input logic              brst_n,
  input logic              srst_n,
  input logic [1:0]        cfg_mode,
  input logic [1:0]        pwr_state,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              clr_tog,
  input logic              clr_pulse,
  input logic [CNT_W-1:0]  count_q,
  input logic              wdt_rst_req
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic       en_c;
  logic [7:0] run_q;

  assign en_c = (cfg_mode == 2'b01) ? (pwr_state == 2'b00) : cfg_mode[1];

  always_ff @(posedge sclk or negedge srst_n) begin
    if (!srst_n) begin
      run_q <= '0;
    end else if (wdt_rst_req) begin
      run_q <= run_q + 8'd1;
    end else begin
      run_q <= '0;
    end
  end

  assert_step_R1: assert property (@(posedge sclk) disable iff (!srst_n)
    (en_c && !clr_pulse && count_q != TOP) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

  assert_wrap_R2: assert property (@(posedge sclk) disable iff (!srst_n)
    (en_c && !clr_pulse && count_q == TOP) |=> (count_q == '0 && wdt_rst_req));

  assert_pulse_len_R2: assert property (@(posedge sclk) disable iff (!srst_n)
    $fell(wdt_rst_req) |-> (run_q == 8'(RST_LEN)));

  assert_pulse_max_R2: assert property (@(posedge sclk) disable iff (!srst_n)
    wdt_rst_req |-> (run_q < 8'(RST_LEN)));

  assert_clear_R3: assert property (@(posedge sclk) disable iff (!srst_n)
    clr_pulse |=> (count_q == '0));

  assert_ignore_R4: assert property (@(posedge clk) disable iff (!brst_n)
    (bus_sel && bus_we && bus_wdata != DATA_W'(KEY)) |=> $stable(clr_tog));

  assert_hold_R5: assert property (@(posedge sclk) disable iff (!srst_n)
    (cfg_mode == 2'b01 && pwr_state != 2'b00 && !clr_pulse) |=> $stable(count_q));

  assert_off_R7: assert property (@(posedge sclk) disable iff (!srst_n)
    (cfg_mode == 2'b00) |=> (!wdt_rst_req && count_q == '0));

endmodule

bind kwdt kwdt_checker #(
  .CNT_W   (CNT_W),
  .RST_LEN (RST_LEN),
  .DATA_W  (DATA_W),
  .KEY     (KEY)
) u_kwdt_checker (
  .clk         (clk),
  .sclk        (sclk),
  .brst_n      (brst_n),
  .srst_n      (srst_n),
  .cfg_mode    (cfg_mode),
  .pwr_state   (pwr_state),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .clr_tog     (clr_tog),
  .clr_pulse   (clr_pulse),
  .count_q     (count_q),
  .wdt_rst_req (wdt_rst_req)
);

// File: tb/kwdt_bench.sv
module kwdt_bench;

  localparam int         CW    = 6;
  localparam int         LIMIT = 1 << CW;
  localparam int         RL    = 2;
  localparam logic [7:0] KEY   = 8'h5A;

  logic       clk;
  logic       sclk;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic [1:0] pwr_state;
  logic       bus_sel;
  logic       bus_we;
  logic       bus_re;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       wdt_rst_req;

  int    tests;
  int    fails;
  int    mcnt;
  int    mpulse;
  int    sedges;
  bit    scen_bad;
  int    sc_act;
  int    sc_exp;
  string cur_tag;
  bit    done;

  kwdt #(.CNT_W(CW), .RST_LEN(RL)) u_kwdt (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .cfg_mode    (cfg_mode),
    .pwr_state   (pwr_state),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_rst_req (wdt_rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    sclk = 1'b0;
    #3;
    forever #80 sclk = ~sclk;
  end

  initial sedges = 0;
  always @(posedge sclk) sedges = sedges + 1;

  function automatic bit en_model(input logic [1:0] m, input logic [1:0] p);
    if (m == 2'b01) return (p == 2'b00);
    return m[1];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic begin_scen(input string tag);
    cur_tag  = tag;
    scen_bad = 1'b0;
    sc_act   = 0;
    sc_exp   = 0;
  endtask

  task automatic end_scen();
    check(!scen_bad, cur_tag, sc_act, sc_exp);
  endtask

  // One slow tick: advance the reference count, then compare the request.
  task automatic step(input bit clr_now);
    bit wrap;
    @(posedge sclk);
    wrap = 1'b0;
    if (clr_now) begin
      mcnt = 0;
    end else if (en_model(cfg_mode, pwr_state)) begin
      if (mcnt == LIMIT - 1) begin
        mcnt = 0;
        wrap = 1'b1;
      end else begin
        mcnt++;
      end
    end
    if (wrap) mpulse = RL;
    else if (mpulse > 0) mpulse--;
    @(negedge sclk);
    if ((wdt_rst_req !== (mpulse != 0)) && !scen_bad) begin
      scen_bad = 1'b1;
      sc_act   = int'(wdt_rst_req);
      sc_exp   = int'(mpulse != 0);
    end
  endtask

  task automatic run(input int n);
    repeat (n) step(1'b0);
  endtask

  task automatic bus_write(input logic [7:0] d, input logic sel, input logic we);
    @(negedge clk);
    bus_sel   = sel;
    bus_we    = we;
    bus_wdata = d;
    @(negedge clk);
    bus_sel   = 1'b0;
    bus_we    = 1'b0;
  endtask

  task automatic key_clear();
    bus_write(KEY, 1'b1, 1'b1);
    step(1'b0);
    step(1'b0);
    step(1'b1);
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_n     = 1'b0;
    cfg_mode  = mode;
    pwr_state = 2'b00;
    bus_sel   = 1'b0;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge sclk);
    rst_n = 1'b1;
    repeat (3) @(negedge sclk);
    mcnt   = 0;
    mpulse = 0;
  endtask

  initial begin
    void'($urandom(32'h5A17));
    tests = 0;
    fails = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    cfg_mode  = 2'b01;
    pwr_state = 2'b00;
    bus_sel   = 1'b0;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    bus_wdata = 8'h00;
    mcnt = 0;
    mpulse = 0;

    // Reset state (R8, R9)
    repeat (5) @(negedge clk);
    check(wdt_rst_req == 1'b0, "R8 request low in reset", int'(wdt_rst_req), 0);
    bus_sel = 1'b1;
    bus_re  = 1'b1;
    #1;
    check(bus_rdata == 8'h00, "R9 read value in reset", int'(bus_rdata), 0);
    @(negedge clk);
    bus_sel = 1'b0;
    bus_re  = 1'b0;

    // R1: overflow after 2^CW enabled ticks
    do_reset(2'b01);
    begin_scen("R1 no request before overflow");
    key_clear();
    run(LIMIT - 1);
    end_scen();
    step(1'b0);
    check(wdt_rst_req == 1'b1, "R1 request at overflow tick", int'(wdt_rst_req), 1);

    // R2: pulse length, wrap and second overflow
    begin_scen("R2 pulse length and wrap");
    run(LIMIT + RL + 3);
    end_scen();

    // R3: key write restarts the count
    begin_scen("R3 key clear restarts count");
    key_clear();
    run(40);
    key_clear();
    run(LIMIT + 5);
    end_scen();

    // R4: wrong data, no select, no write strobe
    begin_scen("R4 non-key writes ignored");
    key_clear();
    run(10);
    for (int i = 0; i < 30; i++) begin
      logic [7:0] d;
      int kind;
      d = 8'($urandom);
      if (d == KEY) d = d ^ 8'h01;
      kind = int'($urandom % 4);
      case (kind)
        0: bus_write(d, 1'b1, 1'b1);
        1: bus_write(KEY, 1'b0, 1'b1);
        2: bus_write(KEY, 1'b1, 1'b0);
        default: bus_write(KEY ^ (8'h01 << ($urandom % 8)), 1'b1, 1'b1);
      endcase
      step(1'b0);
    end
    run(LIMIT);
    end_scen();

    // R5: run-only mode holds outside run state
    do_reset(2'b01);
    begin_scen("R5 run-only hold and resume");
    key_clear();
    run(LIMIT - 1);
    pwr_state = 2'b01;
    run(20);
    pwr_state = 2'b10;
    run(20);
    pwr_state = 2'b00;
    run(RL + 2);
    for (int s = 0; s < 12; s++) begin
      pwr_state = 2'($urandom % 4);
      run(1 + int'($urandom % 30));
    end
    pwr_state = 2'b11;
    run(LIMIT + 10);
    pwr_state = 2'b00;
    end_scen();

    // R6: always-on modes count in every power state
    do_reset(2'b10);
    begin_scen("R6 always-on counts in low power");
    key_clear();
    for (int s = 0; s < 10; s++) begin
      pwr_state = 2'($urandom % 4);
      run(1 + int'($urandom % 25));
    end
    end_scen();
    do_reset(2'b11);
    begin_scen("R6 code 11 counts in power-down");
    key_clear();
    pwr_state = 2'b10;
    run(LIMIT + 2);
    end_scen();
    pwr_state = 2'b00;

    // R7: disabled mode never requests
    do_reset(2'b00);
    begin_scen("R7 disabled never requests");
    key_clear();
    for (int s = 0; s < 6; s++) begin
      run(40);
      bus_write(KEY, 1'b1, 1'b1);
    end
    run(LIMIT + 20);
    end_scen();
    check(wdt_rst_req == 1'b0, "R7 request low when disabled", int'(wdt_rst_req), 0);

    // R9: reads return zero and leave the count alone
    do_reset(2'b01);
    begin_scen("R9 read has no side effect");
    key_clear();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_re    = 1'b1;
      bus_we    = 1'b0;
      bus_wdata = (i % 2 == 0) ? KEY : 8'($urandom);
      #1;
      check(bus_rdata == 8'h00, "R9 read value", int'(bus_rdata), 0);
      @(negedge clk);
      bus_sel = 1'b0;
      bus_re  = 1'b0;
      step(1'b0);
    end
    run(LIMIT);
    end_scen();

    // R10: key write placed close to a slow edge is not dropped
    for (int k = 0; k < 4; k++) begin
      int off;
      int e0;
      int e;
      bit fired;
      begin_scen("R10 lead-in");
      key_clear();
      run(50);
      end_scen();
      off = 70 + int'($urandom % 10);
      #(off);
      e0 = sedges;
      bus_sel   = 1'b1;
      bus_we    = 1'b1;
      bus_wdata = KEY;
      @(posedge clk);
      #1;
      bus_sel = 1'b0;
      bus_we  = 1'b0;
      fired = 1'b0;
      e = 0;
      for (int i = 0; i < 90; i++) begin
        @(negedge sclk);
        if (wdt_rst_req) begin
          fired = 1'b1;
          e = sedges - e0;
          break;
        end
      end
      check(fired && (e == LIMIT + 3 || e == LIMIT + 4), "R10 clear near slow edge", e, LIMIT + 3);
      mcnt   = 0;
      mpulse = RL;
      begin_scen("R10 pulse after late clear");
      run(RL + 2);
      end_scen();
    end

    // R8: reset during a pulse and reset mid-count
    do_reset(2'b01);
    begin_scen("R8 lead-in");
    key_clear();
    run(LIMIT);
    end_scen();
    check(wdt_rst_req == 1'b1, "R8 pulse active before reset", int'(wdt_rst_req), 1);
    rst_n = 1'b0;
    #1;
    check(wdt_rst_req == 1'b0, "R8 reset drops request", int'(wdt_rst_req), 0);
    do_reset(2'b01);
    begin_scen("R8 mid-count lead-in");
    key_clear();
    run(40);
    end_scen();
    do_reset(2'b01);
    begin_scen("R8 count zero after reset");
    run(LIMIT - 4);
    end_scen();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule